// File: doc/BRIEF.md
# Mode Request Validity Checker

This block sits between a software master and the sequencer of a power and clock mode controller. It checks every mode-change request the master makes before the request goes on. Five independent checks run in parallel on each request:
- a request made while a transition is still running;
- a destination that cannot be reached from the present mode;
- a target that is switched off in the mode-enable mask;
- a target code that names no mode;
- a request to leave SAFE while a SAFE event is still pending.

Each check owns a sticky flag in a 32-bit status word. Software clears a flag by writing 1 to it. A request that fails any check is dropped. A request that passes every check is forwarded as a one-cycle accept pulse that carries the target code.

Mode codes are 4 bits wide. RESET=0, TEST=1, SAFE=2, DRUN=3, RUN0..RUN3=4..7, HALT=8, STOP=10, STANDBY=13. Codes 9, 11, 12, 14 and 15 never name a mode. The interrupt output is the OR of the status flags, each gated by its own enable bit.

Top module: `mode_req_checker`

## Requirements
- R1: After reset the status word reads 0 and `irq` is low. Bits 31..5 of `reg_rdata` always read 0, and writing 1s to them changes nothing.
- R2: A request made while `trans_busy` is high sets status bit 4.
- R3: A request to an existing target that cannot be reached from `cur_mode` sets status bit 3. RESET and SAFE can be reached from anywhere. TEST can be reached only from TEST or DRUN. DRUN can be reached from TEST, SAFE, DRUN and RUN0..RUN3. RUN0..RUN3, HALT, STOP and STANDBY can be reached only from DRUN or RUN0..RUN3.
- R4: A request to an existing target whose bit in `mode_en` is 0 sets status bit 2.
- R5: A request to code 9, 11, 12, 14 or 15 sets status bit 1, whatever `mode_en` holds. Such a request never sets bit 2 or bit 3.
- R6: A request sets status bit 0 when `cur_mode` is SAFE, `safe_pend` is high and the target is neither RESET nor SAFE.
- R7: A write with `reg_priv` high clears each status bit that is 1 in `reg_wdata[4:0]`. A 0 in a data bit leaves that status bit as it was.
- R8: A write with `reg_priv` low leaves the status word unchanged.
- R9: When a check sets a bit in the same cycle that a privileged write clears it, the bit ends up set.
- R10: A request that fails no check gives `req_accept` high for exactly the next cycle, with `accept_mode` equal to its target. A request that fails any check gives no pulse.
- R11: `irq` is high exactly when some status bit and its `irq_en` bit are both 1.
- R12: Status bits change one cycle after the request or write that causes the change. They stay set through later valid requests until they are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Mode request strobe, one cycle per request |
| req_mode | input | 4 | Requested target mode code |
| cur_mode | input | 4 | Mode the device is in now |
| trans_busy | input | 1 | A mode transition is in progress |
| safe_pend | input | 1 | A SAFE event is pending |
| mode_en | input | 16 | Per-code enable mask, 1 = mode enabled |
| irq_en | input | 5 | Per-flag interrupt enable |
| reg_wr | input | 1 | Status register write strobe |
| reg_priv | input | 1 | Write comes from a supervisor or test access |
| reg_wdata | input | 32 | Write data, 1 clears the matching flag |
| reg_rdata | output | 32 | Status word read data |
| req_accept | output | 1 | One-cycle pulse for a forwarded request |
| accept_mode | output | 4 | Target of the last forwarded request |
| irq | output | 1 | Masked OR of the status flags |

## Verification
The assertions assume that `cur_mode`, `trans_busy`, `safe_pend` and `mode_en` are steady in any cycle where `req_valid` is high. They also assume that a register write and a request may share a cycle only when the overlap is deliberate. The stimulus changes all of these inputs only on the falling clock edge, together with the request. It holds them until the next step. It makes same-cycle overlaps only in the cases aimed at R9. The scoreboard models the legality table and the sticky set/clear rule on its own.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

    localparam int MODE_W    = 4;
    localparam int NUM_MODES = 1 << MODE_W;
    localparam int NUM_FLAGS = 5;
    localparam int DATA_W    = 32;

    // status bit positions
    localparam int FLG_SAFE   = 0;
    localparam int FLG_ABSENT = 1;
    localparam int FLG_OFF    = 2;
    localparam int FLG_BADDST = 3;
    localparam int FLG_BUSY   = 4;

    localparam logic [MODE_W-1:0] MD_RESET   = 4'd0;
    localparam logic [MODE_W-1:0] MD_TEST    = 4'd1;
    localparam logic [MODE_W-1:0] MD_SAFE    = 4'd2;
    localparam logic [MODE_W-1:0] MD_DRUN    = 4'd3;
    localparam logic [MODE_W-1:0] MD_RUN3    = 4'd7;
    localparam logic [MODE_W-1:0] MD_HALT    = 4'd8;
    localparam logic [MODE_W-1:0] MD_STOP    = 4'd10;
    localparam logic [MODE_W-1:0] MD_STANDBY = 4'd13;

    function automatic logic mode_exists(input logic [MODE_W-1:0] m);
        logic ok;
        case (m)
            4'd9, 4'd11, 4'd12, 4'd14, 4'd15: ok = 1'b0;
            default:                          ok = 1'b1;
        endcase
        return ok;
    endfunction

    // DRUN or one of the RUN modes
    function automatic logic is_active(input logic [MODE_W-1:0] m);
        return (m >= MD_DRUN) && (m <= MD_RUN3);
    endfunction

    function automatic logic dest_reachable(input logic [MODE_W-1:0] cur,
                                            input logic [MODE_W-1:0] tgt);
        logic ok;
        if (tgt == MD_RESET || tgt == MD_SAFE)
            ok = 1'b1;
        else if (tgt == MD_TEST)
            ok = (cur == MD_TEST) || (cur == MD_DRUN);
        else if (tgt == MD_DRUN)
            ok = (cur == MD_TEST) || (cur == MD_SAFE) || is_active(cur);
        else if (is_active(tgt) || tgt == MD_HALT || tgt == MD_STOP || tgt == MD_STANDBY)
            ok = is_active(cur);
        else
            ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/mrc_classify.sv
module mrc_classify
    import mrc_pkg::*;
#(
    parameter int MW = MODE_W,
    parameter int NF = NUM_FLAGS
) (
    input  logic                  req_valid,
    input  logic [MW-1:0]         tgt_mode,
    input  logic [MW-1:0]         cur_mode,
    input  logic                  trans_busy,
    input  logic                  safe_pend,
    input  logic [(1<<MW)-1:0]    mode_en,
    output logic [NF-1:0]         fail_flags
);

    logic tgt_exists;

    always_comb begin
        tgt_exists = mode_exists(tgt_mode);
        fail_flags = '0;
        if (req_valid) begin
            fail_flags[FLG_BUSY]   = trans_busy;
            fail_flags[FLG_ABSENT] = !tgt_exists;
            fail_flags[FLG_OFF]    = tgt_exists && !mode_en[tgt_mode];
            fail_flags[FLG_BADDST] = tgt_exists && !dest_reachable(cur_mode, tgt_mode);
            fail_flags[FLG_SAFE]   = (cur_mode == MD_SAFE) && safe_pend
                                     && (tgt_mode != MD_RESET) && (tgt_mode != MD_SAFE);
        end
    end

endmodule

// File: rtl/mrc_status.sv
module mrc_status
    import mrc_pkg::*;
#(
    parameter int NF = NUM_FLAGS,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic          wr_en,
    input  logic          wr_priv,
    input  logic [DW-1:0] wr_data,
    input  logic [NF-1:0] irq_en,
    output logic [NF-1:0] status_q,
    output logic [DW-1:0] rd_data,
    output logic          irq
);

    typedef struct packed {
        logic [NF-1:0] flags;
    } stat_t;

    stat_t st_d, st_q;
    logic [NF-1:0] clr_mask;
    logic unused_wr_hi;

    assign unused_wr_hi = ^wr_data[DW-1:NF];

    always_comb begin
        clr_mask    = (wr_en && wr_priv) ? wr_data[NF-1:0] : '0;
        st_d.flags  = (st_q.flags & ~clr_mask) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_q           = st_q.flags;
        rd_data            = '0;
        rd_data[NF-1:0]    = st_q.flags;
        irq                = |(st_q.flags & irq_en);
    end

    // R9: a set always lands, even against a clear in the same cycle
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

    // R8: unprivileged write with nothing to set leaves the word alone
    a_r8_unpriv_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_priv && set_i == '0) |=> $stable(status_q));

    // R7: privileged write clears the bits written as 1
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_priv && set_i == '0) |=> ((status_q & $past(wr_data[NF-1:0])) == '0));

    // R12: without a privileged write no bit falls
    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_priv) |=> ((status_q & $past(status_q)) == $past(status_q)));

endmodule

// File: rtl/mode_req_checker.sv
module mode_req_checker
    import mrc_pkg::*;
#(
    parameter int MW = MODE_W,
    parameter int NF = NUM_FLAGS,
    parameter int DW = DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [MW-1:0]         req_mode,
    input  logic [MW-1:0]         cur_mode,
    input  logic                  trans_busy,
    input  logic                  safe_pend,
    input  logic [(1<<MW)-1:0]    mode_en,
    input  logic [NF-1:0]         irq_en,
    input  logic                  reg_wr,
    input  logic                  reg_priv,
    input  logic [DW-1:0]         reg_wdata,
    output logic [DW-1:0]         reg_rdata,
    output logic                  req_accept,
    output logic [MW-1:0]         accept_mode,
    output logic                  irq
);

    typedef struct packed {
        logic          acc;
        logic [MW-1:0] mode;
    } fwd_t;

    logic [NF-1:0] fail_flags;
    logic [NF-1:0] status_q;
    fwd_t fwd_d, fwd_q;

    mrc_classify #(.MW(MW), .NF(NF)) u_classify (
        .req_valid  (req_valid),
        .tgt_mode   (req_mode),
        .cur_mode   (cur_mode),
        .trans_busy (trans_busy),
        .safe_pend  (safe_pend),
        .mode_en    (mode_en),
        .fail_flags (fail_flags)
    );

    mrc_status #(.NF(NF), .DW(DW)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (fail_flags),
        .wr_en    (reg_wr),
        .wr_priv  (reg_priv),
        .wr_data  (reg_wdata),
        .irq_en   (irq_en),
        .status_q (status_q),
        .rd_data  (reg_rdata),
        .irq      (irq)
    );

    always_comb begin
        fwd_d      = fwd_q;
        fwd_d.acc  = req_valid && (fail_flags == '0);
        if (fwd_d.acc) fwd_d.mode = req_mode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fwd_q <= '0;
        else        fwd_q <= fwd_d;
    end

    assign req_accept  = fwd_q.acc;
    assign accept_mode = fwd_q.mode;

    // R2: busy request raises bit 4 next cycle
    a_r2_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && trans_busy) |=> status_q[FLG_BUSY]);

    // R10: busy request is never forwarded
    a_r10_busy_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && trans_busy) |=> !req_accept);

    // R10: no pulse without a request one cycle earlier
    a_r10_pulse_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_accept |-> $past(req_valid));

    // R5: a nameless code never also raises the disabled or unreachable flags
    a_r5_absent_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        fail_flags[FLG_ABSENT] |-> !(fail_flags[FLG_OFF] || fail_flags[FLG_BADDST]));

endmodule

// File: tb/mode_req_checker_tb.sv
module mode_req_checker_tb;

    localparam time TCK = 8ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_mode = '0;
    logic [3:0]  cur_mode = 4'd3;
    logic        trans_busy = 1'b0;
    logic        safe_pend = 1'b0;
    logic [15:0] mode_en = 16'hFFFF;
    logic [4:0]  irq_en = 5'h1F;
    logic        reg_wr = 1'b0;
    logic        reg_priv = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_accept;
    logic [3:0]  accept_mode;
    logic        irq;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic        acc;
        logic [3:0]  mode;
        logic [31:0] rdata;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t sb[$];
    logic [4:0] m_stat = '0;
    logic [3:0] m_mode = '0;

    always #(TCK/2) clk = ~clk;

    mode_req_checker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .cur_mode(cur_mode), .trans_busy(trans_busy), .safe_pend(safe_pend),
        .mode_en(mode_en), .irq_en(irq_en), .reg_wr(reg_wr), .reg_priv(reg_priv),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_accept(req_accept),
        .accept_mode(accept_mode), .irq(irq)
    );

    function automatic logic named(input logic [3:0] m);
        return !(m == 9 || m == 11 || m == 12 || m == 14 || m == 15);
    endfunction

    function automatic logic run_like(input logic [3:0] m);
        return m >= 3 && m <= 7;
    endfunction

    function automatic logic reach(input logic [3:0] c, input logic [3:0] t);
        if (t == 0 || t == 2) return 1'b1;
        if (t == 1)           return c == 1 || c == 3;
        if (t == 3)           return c == 1 || c == 2 || run_like(c);
        return run_like(c);
    endfunction

    function automatic logic [4:0] model_set(input logic [3:0] t);
        logic [4:0] s = '0;
        s[4] = trans_busy;
        s[1] = !named(t);
        s[2] = named(t) && !mode_en[t];
        s[3] = named(t) && !reach(cur_mode, t);
        s[0] = cur_mode == 2 && safe_pend && t != 0 && t != 2;
        return s;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic rv, input logic [3:0] m, input logic wr,
                        input logic pv, input logic [31:0] wd, input string tag);
        exp_t e;
        logic [4:0] set, clr;
        req_valid = rv; req_mode = m;
        reg_wr = wr; reg_priv = pv; reg_wdata = wd;
        set = rv ? model_set(m) : '0;
        clr = (wr && pv) ? wd[4:0] : '0;
        m_stat = (m_stat & ~clr) | set;
        e.acc = rv && set == '0;
        if (e.acc) m_mode = m;
        e.mode = m_mode;
        e.rdata = {27'b0, m_stat};
        e.irq = |(m_stat & irq_en);
        e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
        #1;
        req_valid = 1'b0; reg_wr = 1'b0; reg_priv = 1'b0; reg_wdata = '0;
        @(negedge clk);
    endtask

    // monitor: compare one expected item per clock edge after it was queued
    initial begin
        forever begin
            @(posedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                #2;
                check(e.tag, "req_accept", {31'b0, req_accept}, {31'b0, e.acc});
                if (e.acc) check(e.tag, "accept_mode", {28'b0, accept_mode}, {28'b0, e.mode});
                check(e.tag, "reg_rdata", reg_rdata, e.rdata);
                check(e.tag, "irq", {31'b0, irq}, {31'b0, e.irq});
            end
        end
    end

    initial begin
        #(TCK * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "reg_rdata", reg_rdata, 32'h0);
        check("R1", "irq", {31'b0, irq}, 32'h0);
        check("R1", "req_accept", {31'b0, req_accept}, 32'h0);

        cur_mode = 4'd3;
        step(1, 4'd4, 0, 0, 0, "R10_valid_run0");
        step(1, 4'd1, 0, 0, 0, "R10_valid_test");
        trans_busy = 1;
        step(1, 4'd5, 0, 0, 0, "R2_busy");
        trans_busy = 0;
        step(0, 4'd0, 1, 1, 32'h0, "R7_write_zero");
        step(0, 4'd0, 1, 0, 32'h1F, "R8_unpriv");
        step(0, 4'd0, 1, 1, 32'h10, "R7_clear");
        step(0, 4'd0, 1, 1, 32'hFFFF_FFE0, "R1_upper_ignored");
        cur_mode = 4'd2;
        step(1, 4'd6, 0, 0, 0, "R3_safe_to_run2");
        cur_mode = 4'd8;
        step(1, 4'd3, 0, 0, 0, "R3_halt_to_drun");
        step(0, 4'd0, 1, 1, 32'h08, "R7_clear_bit3");
        cur_mode = 4'd3;
        step(1, 4'd9, 0, 0, 0, "R5_code9");
        mode_en = 16'h0000;
        step(1, 4'd15, 0, 0, 0, "R5_code15_mask_off");
        mode_en = 16'hFEFF;
        step(1, 4'd8, 0, 0, 0, "R4_halt_disabled");
        mode_en = 16'hFFFF;
        step(1, 4'd10, 0, 0, 0, "R12_sticky_valid_req");
        step(0, 4'd0, 1, 1, 32'h1F, "R7_clear_all");
        cur_mode = 4'd2; safe_pend = 1;
        step(1, 4'd3, 0, 0, 0, "R6_safe_pending_drun");
        step(1, 4'd2, 0, 0, 0, "R6_safe_target_ok");
        step(1, 4'd0, 0, 0, 0, "R6_reset_target_ok");
        irq_en = 5'h00;
        step(0, 4'd0, 0, 0, 0, "R11_masked");
        irq_en = 5'h01;
        step(0, 4'd0, 0, 0, 0, "R11_enabled");
        step(0, 4'd0, 1, 1, 32'h01, "R11_cleared");
        irq_en = 5'h1F;
        trans_busy = 1;
        step(1, 4'd12, 0, 0, 0, "R5_multi_fail");
        step(1, 4'd3, 1, 1, 32'h10, "R9_set_beats_clear");
        trans_busy = 0; safe_pend = 0; cur_mode = 4'd3;
        step(0, 4'd0, 1, 1, 32'h1F, "R7_final_clear");
        step(1, 4'd13, 0, 0, 0, "R10_valid_standby");
        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule